// File: doc/BRIEF.md
# Three-Register Instruction Datapath

This block is a small synchronous execution slice built around three 4-bit working registers, here called A, B and C. Every clock cycle it receives a 3-bit operation code and a 4-bit data word. A combinational decoder turns these into a bundle of strobes: register enables, a clear, source selects and flag update enables. The datapath then updates the registers and two sticky status flags on the next rising edge.

The operations clear all registers, load A or B from the data word, copy C into B, and write C with the sum, the AND or a left-shifted B. A further operation compares A and B. The shift distance is taken from the two upper data bits. The add carry and the comparison result are kept in separate flags. Each flag changes only when its own operation runs. No sequencing or memory surrounds the block, so the caller supplies one operation per cycle.

Top module: `trireg_core`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `regA`, `regB`, `regC`, `carryFlag` and `gtFlag` are all 0.
- R2: Opcode 000 (clear) sets A, B and C to 0 at the next edge. Both flags keep their values.
- R3: Opcode 001 loads `dataIn` into A, and opcode 010 loads `dataIn` into B. The other registers are unchanged.
- R4: Opcode 011 (store) writes the value C held before the edge into B. A and C are unchanged.
- R5: Opcode 100 (add) writes (A + B) mod 16 into C and sets `carryFlag` to the unsigned carry out of the 4-bit sum.
- R6: Opcode 101 (shift) writes B shifted left by `dataIn[3:2]` positions (0 to 3) into C, with zeros filling from the right. A and B are unchanged.
- R7: Opcode 110 (compare) sets `gtFlag` to 1 exactly when A > B as unsigned numbers, and to 0 otherwise. No register changes.
- R8: Opcode 111 (and) writes the bitwise AND of A and B into C.
- R9: `carryFlag` changes only on add, and `gtFlag` changes only on compare. Otherwise each flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| opIn | input | 3 | Operation code for this cycle |
| dataIn | input | 4 | Data word; bits 3:2 also give the shift distance |
| regA | output | 4 | Register A contents |
| regB | output | 4 | Register B contents |
| regC | output | 4 | Register C contents |
| carryFlag | output | 1 | Carry out of the most recent add |
| gtFlag | output | 1 | Result of the most recent compare (A > B) |

## Verification
The bench builds the block with its defaults: a 4-bit data width and a 2-bit shift field. With these widths, random data reaches every carry and compare case within a few hundred operations. Directed cases cover the extremes: 15 + 1 and 8 + 8 wrapping to 0 with carry set, 15 + 0 without carry, a shift of 3 that keeps only the lowest bit, and equal operands in a compare. Random opcodes mixed with stores check that C feeds back into B, and that each flag holds its value across the other operations.

// File: rtl/trireg_pkg.sv
package trireg_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR = 3'd0,
    OP_LDA   = 3'd1,
    OP_LDB   = 3'd2,
    OP_STB   = 3'd3,
    OP_ADD   = 3'd4,
    OP_SHL   = 3'd5,
    OP_CMP   = 3'd6,
    OP_AND   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CSRC_SUM = 2'd0,
    CSRC_SHL = 2'd1,
    CSRC_AND = 2'd2
  } csrc_e;

  typedef struct packed {
    logic  clrAll;
    logic  enA;
    logic  enB;
    logic  enC;
    logic  bFromC;
    csrc_e cSrc;
    logic  updCarry;
    logic  updGt;
  } strobe_t;

endpackage

// File: rtl/trireg_ctrl.sv
module trireg_ctrl
  import trireg_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int SHAMT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         opIn,
  input  logic [DATA_W-1:0]  dataIn,
  output strobe_t            strobes,
  output logic [SHAMT_W-1:0] shamt
);

  localparam int SHAMT_LSB = DATA_W - SHAMT_W;

  op_e op;
  assign op = op_e'(opIn);

  // shift distance comes from the top data bits
  assign shamt = dataIn[DATA_W-1:SHAMT_LSB];

  always_comb begin
    strobes          = '0;
    strobes.cSrc     = CSRC_SUM;
    unique case (op)
      OP_CLEAR: strobes.clrAll = 1'b1;
      OP_LDA:   strobes.enA    = 1'b1;
      OP_LDB:   strobes.enB    = 1'b1;
      OP_STB: begin
        strobes.enB    = 1'b1;
        strobes.bFromC = 1'b1;
      end
      OP_ADD: begin
        strobes.enC      = 1'b1;
        strobes.cSrc     = CSRC_SUM;
        strobes.updCarry = 1'b1;
      end
      OP_SHL: begin
        strobes.enC  = 1'b1;
        strobes.cSrc = CSRC_SHL;
      end
      OP_CMP:   strobes.updGt = 1'b1;
      OP_AND: begin
        strobes.enC  = 1'b1;
        strobes.cSrc = CSRC_AND;
      end
      default: ;
    endcase
  end

  // R3: at most one register write strobe (or the clear) per cycle
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.clrAll, strobes.enA, strobes.enB, strobes.enC}));

  // R9: the two flag updates never coincide
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobes.updCarry && strobes.updGt));

endmodule

// File: rtl/trireg_dp.sv
module trireg_dp
  import trireg_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int SHAMT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobes,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [DATA_W-1:0]  regA,
  output logic [DATA_W-1:0]  regB,
  output logic [DATA_W-1:0]  regC,
  output logic               carryFlag,
  output logic               gtFlag
);

  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0]  sumWide;
  logic [DATA_W-1:0] andRes;
  logic [DATA_W-1:0] shlRes;
  logic [DATA_W-1:0] cNext;
  logic [DATA_W-1:0] bNext;
  logic              aGtB;

  // unsigned add with carry out
  assign sumWide = {1'b0, regA} + {1'b0, regB};
  assign andRes  = regA & regB;
  assign aGtB    = regA > regB;

  // logarithmic left shifter: stage s moves by 2**s when shamt[s] is set
  logic [DATA_W-1:0] shStage [SHAMT_W+1];
  assign shStage[0] = regB;
  for (genvar s = 0; s < SHAMT_W; s++) begin : g_shl
    assign shStage[s+1] = shamt[s] ? (shStage[s] << (1 << s)) : shStage[s];
  end
  assign shlRes = shStage[SHAMT_W];

  always_comb begin
    unique case (strobes.cSrc)
      CSRC_SHL: cNext = shlRes;
      CSRC_AND: cNext = andRes;
      default:  cNext = sumWide[DATA_W-1:0];
    endcase
  end

  assign bNext = strobes.bFromC ? regC : dataIn;

  always_ff @(posedge clk) begin
    if (rst || strobes.clrAll) begin
      regA <= '0;
      regB <= '0;
      regC <= '0;
    end else begin
      if (strobes.enA) regA <= dataIn;
      if (strobes.enB) regB <= bNext;
      if (strobes.enC) regC <= cNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carryFlag <= 1'b0;
      gtFlag    <= 1'b0;
    end else begin
      if (strobes.updCarry) carryFlag <= sumWide[DATA_W];
      if (strobes.updGt)    gtFlag    <= aGtB;
    end
  end

  // R2
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.clrAll |=> (regA == '0 && regB == '0 && regC == '0));

  // R4
  store_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.enB && strobes.bFromC) |=> regB == $past(regC));

  // R7
  cmp_result_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.updGt |=> gtFlag == ($past(regA) > $past(regB)));

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.updCarry |=> $stable(carryFlag));

  // R9
  gt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.updGt |=> $stable(gtFlag));

endmodule

// File: rtl/trireg_core.sv
module trireg_core
  import trireg_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int SHAMT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        opIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic              carryFlag,
  output logic              gtFlag
);

  strobe_t            strobes;
  logic [SHAMT_W-1:0] shamt;

  trireg_ctrl #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opIn    (opIn),
    .dataIn  (dataIn),
    .strobes (strobes),
    .shamt   (shamt)
  );

  trireg_dp #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .shamt     (shamt),
    .dataIn    (dataIn),
    .regA      (regA),
    .regB      (regB),
    .regC      (regC),
    .carryFlag (carryFlag),
    .gtFlag    (gtFlag)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (regA == '0 && regB == '0 && regC == '0 && !carryFlag && !gtFlag));

endmodule

// File: tb/test_trireg_core.sv
`timescale 1ns/1ps
module test_trireg_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] opIn = 3'd0;
  logic [3:0] dataIn = 4'd0;
  logic [3:0] regA, regB, regC;
  logic       carryFlag, gtFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] mA = '0, mB = '0, mC = '0;
  logic       mCy = 1'b0, mGt = 1'b0;

  always #2.5 clk = ~clk;

  trireg_core i_trireg_core (
    .clk(clk), .rst(rst), .opIn(opIn), .dataIn(dataIn),
    .regA(regA), .regB(regB), .regC(regC),
    .carryFlag(carryFlag), .gtFlag(gtFlag)
  );

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkAll(input string tag);
    checks++;
    if (regA !== mA || regB !== mB || regC !== mC) begin
      fails++;
      $display("FAIL %s regs: actual A=%h B=%h C=%h expected A=%h B=%h C=%h",
               tag, regA, regB, regC, mA, mB, mC);
    end
    checks++;
    if (carryFlag !== mCy || gtFlag !== mGt) begin
      fails++;
      $display("FAIL %s/R9 flags: actual cy=%b gt=%b expected cy=%b gt=%b",
               tag, carryFlag, gtFlag, mCy, mGt);
    end
  endtask

  // called at a falling edge; result is checked at the next falling edge
  task automatic doOp(input logic [2:0] op, input logic [3:0] d);
    logic [4:0] s;
    opIn   = op;
    dataIn = d;
    s = {1'b0, mA} + {1'b0, mB};
    case (op)
      3'd0: begin mA = '0; mB = '0; mC = '0; end
      3'd1: mA = d;
      3'd2: mB = d;
      3'd3: mB = mC;
      3'd4: begin mC = s[3:0]; mCy = s[4]; end
      3'd5: mC = mB << d[3:2];
      3'd6: mGt = (mA > mB);
      default: mC = mA & mB;
    endcase
    @(negedge clk);
    checkAll(tagOf(op));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    opIn = 3'd3; dataIn = 4'hF;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1");
    rst = 1'b0;

    // directed corner cases
    doOp(3'd1, 4'hF); doOp(3'd2, 4'h1); doOp(3'd4, 4'h0);   // R5 15+1 wraps, carry
    doOp(3'd6, 4'h0);                                       // R7 15>1
    doOp(3'd1, 4'h8); doOp(3'd2, 4'h8); doOp(3'd4, 4'h0);   // R5 8+8
    doOp(3'd6, 4'h0);                                       // R7 equal -> 0
    doOp(3'd1, 4'hF); doOp(3'd2, 4'h0); doOp(3'd4, 4'h3);   // R5 no carry
    doOp(3'd2, 4'hF); doOp(3'd5, 4'hC);                     // R6 shift by 3
    doOp(3'd5, 4'h3);                                       // R6 shift by 0
    doOp(3'd1, 4'hA); doOp(3'd7, 4'h0);                     // R8
    doOp(3'd3, 4'h5);                                       // R4 store
    doOp(3'd0, 4'hF);                                       // R2 clear, flags kept

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(7, 0));
      if (op == 3'd0 && ($urandom_range(3, 0) != 0)) op = 3'd4;
      doOp(op, 4'($urandom_range(15, 0)));
    end

    // R1: reset again after activity
    rst = 1'b1;
    mA = '0; mB = '0; mC = '0; mCy = 1'b0; mGt = 1'b0;
    @(negedge clk);
    checkAll("R1");
    rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule